// File: doc/BRIEF.md
# Dual-Modulus Synthesizer Divider Pair

This block holds the two programmable dividers that feed the phase detector of a frequency synthesizer. The VCO-side divider is a swallow-counter arrangement around a 16/17 dual-modulus prescaler. It is modelled as counters running in one clock domain and advanced by a VCO-rate clock enable. The reference-side divider is a plain programmable down-counter advanced by a reference-rate clock enable. At the end of every divide period, each divider raises a one-clock pulse at the comparison rate.

Two banks of ratios sit at the inputs, each holding one VCO ratio and one reference ratio. A bank select picks which bank the dividers use. A newly selected bank or a newly written ratio only takes effect when the running period ends. This keeps the phase detector from ever seeing a shortened period while the loop is retuned. After reset, each divider runs a fixed default ratio for its first period. That default depends on the bank chosen while reset is asserted.

Top module: `synth_divider_pair`

## Requirements
- R1: While rst_n is low, m_pulse and r_pulse are low. A reset in the middle of a period discards the partial count, and counting starts over from a full period.
- R2: The first VCO period after reset lasts 10519 enabled cycles if bank_sel is high during reset and 4269 if it is low. The first reference period lasts 492 enabled cycles. The ratio inputs have no effect before the first terminal count.
- R3: A VCO ratio word carries its main count P in bits 13:4 and its swallow count A in bits 3:0. The VCO period is 16·P + A enabled cycles, for any word from 256 to 16383 with P ≥ A. Within each period the prescaler divides by 17 for its first A cycles and by 16 for the remaining P − A cycles.
- R4: m_pulse is high for exactly one clock, in the cycle after the enabled cycle that completes the VCO count. Cycles with vco_en low do not advance the VCO divider.
- R5: The reference period equals the 11-bit reference ratio in enabled cycles, for any value from 2 to 2047.
- R6: r_pulse is high for exactly one clock, in the cycle after the enabled cycle that completes the reference count. Cycles with ref_en low do not advance the reference divider.
- R7: bank_sel high selects m_ratio_b1 and r_ratio_b1. bank_sel low selects m_ratio_b2 and r_ratio_b2. The select applies to both dividers.
- R8: A change of bank_sel or of a ratio input in the middle of a period does not alter that period. The new ratio is taken at the terminal count and governs the following period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both dividers |
| rst_n | input | 1 | Synchronous reset, active low |
| vco_en | input | 1 | Advances the VCO-side divider by one VCO cycle |
| ref_en | input | 1 | Advances the reference-side divider by one reference cycle |
| bank_sel | input | 1 | High selects bank 1, low selects bank 2 |
| m_ratio_b1 | input | 14 | VCO ratio of bank 1, P in 13:4 and A in 3:0 |
| m_ratio_b2 | input | 14 | VCO ratio of bank 2, same layout |
| r_ratio_b1 | input | 11 | Reference ratio of bank 1 |
| r_ratio_b2 | input | 11 | Reference ratio of bank 2 |
| m_pulse | output | 1 | One-clock pulse at each VCO-side terminal count |
| r_pulse | output | 1 | One-clock pulse at each reference-side terminal count |

## Verification
The hardest case to reach is a bank or ratio change that lands part-way through a period. To get there, the stimulus waits for a pulse, lets a few enabled cycles pass, and then flips the select or rewrites the active ratio. It then measures the period in progress and the period after it. Periods are counted in enabled cycles rather than clocks, so the same expectations hold while the enables are gated at one in two or one in three cycles. The reset defaults are reached by holding small ratios at the inputs through reset. The first period must still show the large default values.

// File: rtl/synth_div_pkg.sv
// Shared widths, defaults and the VCO ratio word layout for the divider pair.
package synth_div_pkg;
    localparam int SWALLOW_W = 4;
    localparam int MAIN_W    = 10;
    localparam int MRATIO_W  = SWALLOW_W + MAIN_W;
    localparam int RRATIO_W  = 11;
    localparam int PRE_LOW   = 16;

    // VCO ratio word: main count in the upper bits, swallow count in the lower bits
    typedef struct packed {
        logic [MAIN_W-1:0]    main_cnt;
        logic [SWALLOW_W-1:0] swallow;
    } mratio_t;

    // Reinterpret a flat ratio word as its two counter fields
    function automatic mratio_t split_mratio(input logic [MRATIO_W-1:0] word);
        return mratio_t'(word);
    endfunction
endpackage

// File: rtl/dm_prescaler.sv
// Dual-modulus prescaler model: counts enabled VCO cycles and flags the last
// cycle of each prescaler period, dividing by LOW_MOD or LOW_MOD+1.
// Assumes mod_high only changes on a cycle where cyc_done was high.
module dm_prescaler #(
    parameter int LOW_MOD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic mod_high,
    output logic cyc_done
);
    localparam int CW = $clog2(LOW_MOD + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_val;

    // Terminal value of the running prescaler period
    always_comb last_val = mod_high ? CW'(LOW_MOD) : CW'(LOW_MOD - 1);

    // End of a prescaler period on an enabled cycle
    always_comb cyc_done = en && (cnt_q == last_val);

    // Prescaler position within its current period
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (cyc_done) cnt_q <= '0;
        else if (en)       cnt_q <= cnt_q + 1'b1;
    end

    // R3
    extra_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CW'(LOW_MOD)) |-> mod_high);
endmodule

// File: rtl/swallow_ctrl.sv
// Swallow and main counters of the VCO-side divider. Counts prescaler periods,
// holds the prescaler at the high modulus while swallow cycles remain, and
// pulses at the last prescaler period, reloading from the offered ratio.
// Assumes every loaded ratio has main >= PRE_LOW and main >= swallow.
module swallow_ctrl #(
    parameter int A_W     = 4,
    parameter int P_W     = 10,
    parameter int PRE_LOW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pre_done,
    input  logic [A_W-1:0] nxt_a,
    input  logic [P_W-1:0] nxt_p,
    input  logic [A_W-1:0] rst_a,
    input  logic [P_W-1:0] rst_p,
    output logic           mod_high,
    output logic           m_pulse
);
    logic [A_W-1:0] a_left_q;
    logic [P_W-1:0] p_left_q;
    logic           term;

    // Swallow cycles remaining keep the prescaler at the high modulus
    always_comb mod_high = (a_left_q != '0);

    // Last prescaler period of the output period completes
    always_comb term = pre_done && (p_left_q == P_W'(1));

    // Counter state and registered terminal pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_left_q <= rst_a;
            p_left_q <= rst_p;
            m_pulse  <= 1'b0;
        end else begin
            m_pulse <= term;
            if (term) begin
                a_left_q <= nxt_a;
                p_left_q <= nxt_p;
            end else if (pre_done) begin
                p_left_q <= p_left_q - 1'b1;
                if (a_left_q != '0) a_left_q <= a_left_q - 1'b1;
            end
        end
    end

    // R3
    swallow_within_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        P_W'(a_left_q) <= p_left_q);
    // R3
    ratio_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term |-> (nxt_p >= P_W'(PRE_LOW) && nxt_p >= P_W'(nxt_a)));
    // R4
    m_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_pulse |=> !m_pulse);
endmodule

// File: rtl/ref_divider.sv
// Programmable reference divider: counts enabled reference cycles down from
// the loaded ratio and pulses once per period, reloading at the terminal count.
// Assumes every loaded ratio is at least 2.
module ref_divider #(
    parameter int R_W = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [R_W-1:0] nxt_r,
    input  logic [R_W-1:0] rst_r,
    output logic           r_pulse
);
    logic [R_W-1:0] cnt_q;
    logic           term;

    // Final enabled cycle of the reference period
    always_comb term = en && (cnt_q == R_W'(1));

    // Down-counter and registered terminal pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= rst_r;
            r_pulse <= 1'b0;
        end else begin
            r_pulse <= term;
            if (term)    cnt_q <= nxt_r;
            else if (en) cnt_q <= cnt_q - 1'b1;
        end
    end

    // R5
    r_load_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term |-> (nxt_r >= R_W'(2)));
    // R5
    r_cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != '0);
    // R6
    r_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_pulse |=> !r_pulse);
endmodule

// File: rtl/synth_divider_pair.sv
// Divider pair for a synthesizer: a swallow-counter VCO divider around a
// dual-modulus prescaler and a plain reference divider. Both take their ratio
// from the bank chosen by bank_sel at each terminal count; reset loads defaults.
// Assumes ratio inputs are legal whenever a terminal count can occur.
module synth_divider_pair
    import synth_div_pkg::*;
#(
    parameter int DEF_M1 = 10519,
    parameter int DEF_M2 = 4269,
    parameter int DEF_R  = 492
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vco_en,
    input  logic                ref_en,
    input  logic                bank_sel,
    input  logic [MRATIO_W-1:0] m_ratio_b1,
    input  logic [MRATIO_W-1:0] m_ratio_b2,
    input  logic [RRATIO_W-1:0] r_ratio_b1,
    input  logic [RRATIO_W-1:0] r_ratio_b2,
    output logic                m_pulse,
    output logic                r_pulse
);
    mratio_t             m_next;
    mratio_t             m_reset;
    logic [RRATIO_W-1:0] r_next;
    logic                mod_high;
    logic                pre_done;

    // Ratio offered to the VCO divider at its next terminal count
    always_comb m_next = split_mratio(bank_sel ? m_ratio_b1 : m_ratio_b2);

    // Default VCO ratio of the bank chosen during reset
    always_comb m_reset = split_mratio(bank_sel ? MRATIO_W'(DEF_M1) : MRATIO_W'(DEF_M2));

    // Ratio offered to the reference divider at its next terminal count
    always_comb r_next = bank_sel ? r_ratio_b1 : r_ratio_b2;

    dm_prescaler #(.LOW_MOD(PRE_LOW)) pre_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (vco_en),
        .mod_high (mod_high),
        .cyc_done (pre_done)
    );

    swallow_ctrl #(.A_W(SWALLOW_W), .P_W(MAIN_W), .PRE_LOW(PRE_LOW)) swc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pre_done (pre_done),
        .nxt_a    (m_next.swallow),
        .nxt_p    (m_next.main_cnt),
        .rst_a    (m_reset.swallow),
        .rst_p    (m_reset.main_cnt),
        .mod_high (mod_high),
        .m_pulse  (m_pulse)
    );

    ref_divider #(.R_W(RRATIO_W)) rdiv_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ref_en),
        .nxt_r   (r_next),
        .rst_r   (RRATIO_W'(DEF_R)),
        .r_pulse (r_pulse)
    );

    // R4
    m_pulse_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_pulse |-> $past(vco_en));
    // R6
    r_pulse_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_pulse |-> $past(ref_en));
endmodule

// File: tb/synth_divider_pair_tb.sv
module synth_divider_pair_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vco_en = 1'b0;
    logic        ref_en = 1'b0;
    logic        bank_sel = 1'b1;
    logic [13:0] m_ratio_b1 = 14'd256;
    logic [13:0] m_ratio_b2 = 14'd300;
    logic [10:0] r_ratio_b1 = 11'd2;
    logic [10:0] r_ratio_b2 = 11'd5;
    logic        m_pulse;
    logic        r_pulse;

    int checks = 0;
    int failures = 0;
    int en_mode = 0;

    always #4 clk = ~clk;

    synth_divider_pair dut_i (
        .clk(clk), .rst_n(rst_n), .vco_en(vco_en), .ref_en(ref_en),
        .bank_sel(bank_sel), .m_ratio_b1(m_ratio_b1), .m_ratio_b2(m_ratio_b2),
        .r_ratio_b1(r_ratio_b1), .r_ratio_b2(r_ratio_b2),
        .m_pulse(m_pulse), .r_pulse(r_pulse)
    );

    // enable patterns: 0 both always, 1 alternate cycles, 2 one cycle in three
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(posedge clk); #2;
            ph++;
            case (en_mode)
                1:       begin vco_en = ph[0];        ref_en = ~ph[0];       end
                2:       begin vco_en = (ph % 3 == 0); ref_en = (ph % 3 == 1); end
                default: begin vco_en = 1'b1;         ref_en = 1'b1;         end
            endcase
        end
    end

    // period monitor, counting enabled cycles between pulses
    int  m_acc = 0, r_acc = 0, m_last = 0, r_last = 0, m_first = 0, r_first = 0;
    int  m_n = 0, r_n = 0, dbl_m = 0, dbl_r = 0;
    bit  m_fresh = 1, r_fresh = 1, v_prev = 0, f_prev = 0, rs_prev = 0, mp_prev = 0, rp_prev = 0;
    always @(negedge clk) begin
        if (!rs_prev) begin
            m_acc = 0; r_acc = 0; m_fresh = 1; r_fresh = 1;
        end else begin
            if (v_prev) m_acc++;
            if (f_prev) r_acc++;
        end
        if (m_pulse) begin
            if (mp_prev) dbl_m++;
            if (m_fresh) m_first = m_acc;
            m_fresh = 0; m_last = m_acc; m_acc = 0; m_n++;
        end
        if (r_pulse) begin
            if (rp_prev) dbl_r++;
            if (r_fresh) r_first = r_acc;
            r_fresh = 0; r_last = r_acc; r_acc = 0; r_n++;
        end
        mp_prev = m_pulse; rp_prev = r_pulse;
        v_prev = vco_en; f_prev = ref_en; rs_prev = rst_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_m(input int n);
        int target;
        target = m_n + n;
        while (m_n < target) @(posedge clk);
    endtask

    task automatic wait_r(input int n);
        int target;
        target = r_n + n;
        while (r_n < target) @(posedge clk);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    typedef struct packed {
        logic        sel;
        logic [13:0] m1;
        logic [13:0] m2;
        logic [10:0] r1;
        logic [10:0] r2;
        logic [1:0]  mode;
        logic [13:0] exp_m;
        logic [10:0] exp_r;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 14'd256,  14'd300,  11'd2,    11'd5,    2'd0, 14'd256,  11'd2},
        '{1'b0, 14'd256,  14'd300,  11'd2,    11'd5,    2'd0, 14'd300,  11'd5},
        '{1'b0, 14'd256,  14'd271,  11'd2,    11'd2047, 2'd1, 14'd271,  11'd2047},
        '{1'b1, 14'd529,  14'd271,  11'd3,    11'd2047, 2'd2, 14'd529,  11'd3},
        '{1'b0, 14'd529,  14'd1000, 11'd3,    11'd11,   2'd1, 14'd1000, 11'd11},
        '{1'b1, 14'd4097, 14'd1000, 11'd1024, 11'd11,   2'd0, 14'd4097, 11'd1024}
    };

    initial begin
        // R1 outputs low while reset is held
        cycles(6);
        chk(m_pulse == 1'b0, "R1 m_pulse in reset", m_pulse, 0);
        chk(r_pulse == 1'b0, "R1 r_pulse in reset", r_pulse, 0);
        @(posedge clk); #2 rst_n = 1'b1;

        // R2 defaults with bank 1 selected at reset; inputs ignored for first period
        wait_m(2);
        chk(m_first == 10519, "R2 first m period bank1", m_first, 10519);
        chk(m_last == 256, "R2 R7 m period after load", m_last, 256);
        chk(r_first == 492, "R2 first r period", r_first, 492);
        chk(r_last == 2, "R5 r period after load", r_last, 2);

        // R1 mid-period reset, then R2 default of bank 2 with gated enables
        cycles(100);
        rst_n = 1'b0; bank_sel = 1'b0; en_mode = 1;
        cycles(3);
        chk(m_pulse == 1'b0 && r_pulse == 1'b0, "R1 outputs after mid-run reset", m_pulse, 0);
        rst_n = 1'b1;
        wait_m(1);
        chk(m_first == 4269, "R1 R2 first m period bank2", m_first, 4269);
        chk(r_first == 492, "R1 R2 first r period bank2", r_first, 492);

        // R3 R4 R5 R6 R7 vector table
        for (int i = 0; i < NV; i++) begin
            bank_sel = VECS[i].sel;
            m_ratio_b1 = VECS[i].m1; m_ratio_b2 = VECS[i].m2;
            r_ratio_b1 = VECS[i].r1; r_ratio_b2 = VECS[i].r2;
            en_mode = int'(VECS[i].mode);
            wait_m(2);
            chk(m_last == int'(VECS[i].exp_m), "R3 R4 R7 m period", m_last, int'(VECS[i].exp_m));
            wait_r(2);
            chk(r_last == int'(VECS[i].exp_r), "R5 R6 R7 r period", r_last, int'(VECS[i].exp_r));
        end

        // R8 bank switch part-way through a period
        en_mode = 0; bank_sel = 1'b1;
        m_ratio_b1 = 14'd256; m_ratio_b2 = 14'd300; r_ratio_b1 = 11'd20; r_ratio_b2 = 11'd30;
        wait_m(2); wait_r(2);
        wait_r(1); cycles(5);
        bank_sel = 1'b0;
        wait_r(1);
        chk(r_last == 20, "R8 r period spanning switch", r_last, 20);
        wait_r(1);
        chk(r_last == 30, "R8 R7 r period after switch", r_last, 30);
        wait_m(1);
        chk(m_last == 256, "R8 m period spanning switch", m_last, 256);
        wait_m(1);
        chk(m_last == 300, "R8 R7 m period after switch", m_last, 300);

        // R8 rewrite of the active ratio part-way through a period
        wait_m(1); cycles(40);
        m_ratio_b2 = 14'd320;
        wait_m(1);
        chk(m_last == 300, "R8 m period spanning rewrite", m_last, 300);
        wait_m(1);
        chk(m_last == 320, "R8 m period after rewrite", m_last, 320);

        // R3 largest ratio, P=1023 A=15
        bank_sel = 1'b1; m_ratio_b1 = 14'd16383;
        wait_m(2);
        chk(m_last == 16383, "R3 maximum m period", m_last, 16383);

        // R4 R6 pulses never wider than one clock
        chk(dbl_m == 0, "R4 m_pulse width", dbl_m, 0);
        chk(dbl_r == 0, "R6 r_pulse width", dbl_r, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule